// File: doc/BRIEF.md
# Folded Circulant Message Memory Mapper

This block lets the edge messages of several circulant submatrices live in one deep RAM, so a decoder does not need one memory per circulant. Each submatrix gets its own region of `CIRC_SIZE` entries in the shared RAM. Which region is in use is set by a fold index. Inside a region, the row index is rotated by that submatrix's cyclic offset. The offsets sit in a small per-fold register array, and software loads them one fold at a time.

A pulse on `start` launches one pass over the folded submatrices, either a write pass or a read pass. A pass serves as one half of a decoding phase. It visits the folds in ascending order and issues one RAM access per clock. On a write pass the caller supplies the message for the step shown on `step_fold`/`step_row`. On a read pass the message returns one cycle later, labelled with the fold and row it belongs to. The number of folds is taken when the pass starts, and `done` marks the end of the pass. Processing of the message values is outside this block.

Top module: `fold_msg_mapper`

## Requirements
- R1: After synchronous reset, `busy`, `done` and `rd_valid` are 0 and every fold offset is 0.
- R2: The step for fold f and row r accesses the physical entry f*CIRC_SIZE + ((r + offset[f]) mod CIRC_SIZE). CIRC_SIZE is a power of two, so the fold index forms the upper address bits.
- R3: A pass starts its first step on the cycle after `start` is accepted and then makes one step per cycle. It runs fold 0 first, with rows 0 to CIRC_SIZE-1 in rising order, then fold 1, and continues up to the last fold. During each step, `busy`=1 and `step_fold`/`step_row` show that step.
- R4: `cfg_fold_cnt` is captured when `start` is accepted. A value of 0 runs one fold, and values above MAX_FOLDS run MAX_FOLDS folds.
- R5: `done` is high for exactly one cycle, the cycle right after the last step. `busy` drops in that same cycle.
- R6: On a read pass, the data for a step appears on `rd_data` one cycle later with `rd_valid`=1. `rd_fold`/`rd_row` carry that step's fold and row.
- R7: On a write pass, `wr_data` is stored at the step's physical entry during each step, and `rd_valid` stays 0 for the whole pass.
- R8: A `start` pulse that arrives while `busy`=1 has no effect. The pass in progress keeps its order and fold count.
- R9: Messages stored for different folds never overwrite each other. A fold that a later, shorter write pass does not cover keeps its earlier data.
- R10: A cycle with `cfg_off_we`=1 loads `cfg_off_val` into the offset of fold `cfg_off_idx`, and every later step of that fold uses the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_off_we | input | 1 | Offset register write strobe |
| cfg_off_idx | input | FOLD_W | Fold whose offset is written |
| cfg_off_val | input | ROW_W | New cyclic offset |
| cfg_fold_cnt | input | FOLD_W+1 | Number of folds for the next pass |
| start | input | 1 | Launch a pass when idle |
| start_write | input | 1 | 1 = write pass, 0 = read pass |
| wr_data | input | MSG_W | Message written on the current step |
| busy | output | 1 | A pass is running |
| step_fold | output | FOLD_W | Fold of the current step |
| step_row | output | ROW_W | Row of the current step |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | MSG_W | Message read from the shared RAM |
| rd_fold | output | FOLD_W | Fold that `rd_data` belongs to |
| rd_row | output | ROW_W | Row that `rd_data` belongs to |
| done | output | 1 | One-cycle end-of-pass pulse |

## Verification
Getting the per-fold rotation wrong is the hardest fault to expose from the ports. A write pass followed by a read pass with the same offsets returns every tag intact, whatever the rotation is. The stimulus therefore writes tags that encode fold and row, loads new offsets, and reads again. Each returned tag must then name the row whose rotated address matches the new one. A shorter write pass with a clamped fold count, and a `start` pulse in the middle of a pass, cover region isolation and the ignored restart.

// File: rtl/fold_pkg.sv
package fold_pkg;
  typedef enum logic {
    PASS_READ  = 1'b0,
    PASS_WRITE = 1'b1
  } pass_e;
endpackage

// File: rtl/fold_offset_regs.sv
module fold_offset_regs #(
  parameter int MAX_FOLDS = 8,
  parameter int FOLD_W    = 3,
  parameter int ROW_W     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [FOLD_W-1:0] wr_idx,
  input  logic [ROW_W-1:0]  wr_val,
  input  logic [FOLD_W-1:0] rd_idx,
  output logic [ROW_W-1:0]  rd_off
);
  logic [ROW_W-1:0] off_q [MAX_FOLDS];

  for (genvar g = 0; g < MAX_FOLDS; g++) begin : g_off
    always_ff @(posedge clk) begin
      if (rst)
        off_q[g] <= '0;
      else if (we && wr_idx == FOLD_W'(g))
        off_q[g] <= wr_val;
    end
  end

  assign rd_off = off_q[rd_idx];
endmodule

// File: rtl/fold_sequencer.sv
module fold_sequencer
  import fold_pkg::*;
#(
  parameter int CIRC_SIZE = 256,
  parameter int MAX_FOLDS = 8,
  parameter int FOLD_W    = 3,
  parameter int ROW_W     = 8,
  parameter int CNT_W     = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              start_write,
  input  logic [CNT_W-1:0]  fold_cnt,
  output logic              busy,
  output logic [FOLD_W-1:0] fold,
  output logic [ROW_W-1:0]  row,
  output logic              write_mode,
  output logic              done
);
  localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(CIRC_SIZE - 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(MAX_FOLDS);

  logic              busy_q, done_q;
  logic [FOLD_W-1:0] fold_q;
  logic [ROW_W-1:0]  row_q;
  logic [CNT_W-1:0]  nfolds_q, nfolds_d;
  pass_e             mode_q;
  logic              last_row, last_fold;

  always_comb begin
    if (fold_cnt == '0)
      nfolds_d = CNT_W'(1);
    else if (fold_cnt > CNT_MAX)
      nfolds_d = CNT_MAX;
    else
      nfolds_d = fold_cnt;
  end

  assign last_row  = (row_q == LAST_ROW);
  assign last_fold = ({1'b0, fold_q} == nfolds_q - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      fold_q   <= '0;
      row_q    <= '0;
      nfolds_q <= CNT_W'(1);
      mode_q   <= PASS_READ;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start) begin
          busy_q   <= 1'b1;
          fold_q   <= '0;
          row_q    <= '0;
          nfolds_q <= nfolds_d;
          mode_q   <= start_write ? PASS_WRITE : PASS_READ;
        end
      end else if (last_row) begin
        row_q <= '0;
        if (last_fold) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          fold_q <= '0;
        end else begin
          fold_q <= fold_q + 1'b1;
        end
      end else begin
        row_q <= row_q + 1'b1;
      end
    end
  end

  assign busy       = busy_q;
  assign fold       = fold_q;
  assign row        = row_q;
  assign write_mode = (mode_q == PASS_WRITE);
  assign done       = done_q;

  assert_row_step_R3: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !last_row) |=> (busy_q && row_q == $past(row_q) + 1'b1 && fold_q == $past(fold_q)));

  assert_fold_bound_R4: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> ({1'b0, fold_q} < nfolds_q && nfolds_q <= CNT_MAX));

  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);

  assert_done_at_end_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_q) |-> done_q);

  assert_start_ignored_R8: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !last_row) |=> $stable(nfolds_q) && $stable(mode_q));
endmodule

// File: rtl/fold_addr_gen.sv
module fold_addr_gen #(
  parameter int FOLD_W = 3,
  parameter int ROW_W  = 8,
  parameter int ADDR_W = 11
) (
  input  logic [FOLD_W-1:0] fold,
  input  logic [ROW_W-1:0]  row,
  input  logic [ROW_W-1:0]  offset,
  output logic [ADDR_W-1:0] addr
);
  logic [ROW_W-1:0] rot_row;

  // Power-of-two circulant size: the sum wraps modulo CIRC_SIZE by width.
  assign rot_row = row + offset;
  assign addr    = {fold, rot_row};
endmodule

// File: rtl/fold_msg_ram.sv
module fold_msg_ram #(
  parameter int DEPTH  = 2048,
  parameter int ADDR_W = 11,
  parameter int MSG_W  = 8,
  parameter int FOLD_W = 3,
  parameter int ROW_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [MSG_W-1:0]  wdata,
  input  logic [FOLD_W-1:0] tag_fold,
  input  logic [ROW_W-1:0]  tag_row,
  output logic              rd_valid,
  output logic [MSG_W-1:0]  rd_data,
  output logic [FOLD_W-1:0] rd_fold,
  output logic [ROW_W-1:0]  rd_row
);
  logic [MSG_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en && we)
      mem[addr] <= wdata;
    if (en && !we)
      rd_data <= mem[addr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_fold  <= '0;
      rd_row   <= '0;
    end else begin
      rd_valid <= en && !we;
      rd_fold  <= tag_fold;
      rd_row   <= tag_row;
    end
  end
endmodule

// File: rtl/fold_msg_mapper.sv
module fold_msg_mapper #(
  parameter int CIRC_SIZE = 256,
  parameter int MAX_FOLDS = 8,
  parameter int MSG_W     = 8,
  parameter int ROW_W     = $clog2(CIRC_SIZE),
  parameter int FOLD_W    = $clog2(MAX_FOLDS),
  parameter int CNT_W     = FOLD_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_off_we,
  input  logic [FOLD_W-1:0] cfg_off_idx,
  input  logic [ROW_W-1:0]  cfg_off_val,
  input  logic [CNT_W-1:0]  cfg_fold_cnt,
  input  logic              start,
  input  logic              start_write,
  input  logic [MSG_W-1:0]  wr_data,
  output logic              busy,
  output logic [FOLD_W-1:0] step_fold,
  output logic [ROW_W-1:0]  step_row,
  output logic              rd_valid,
  output logic [MSG_W-1:0]  rd_data,
  output logic [FOLD_W-1:0] rd_fold,
  output logic [ROW_W-1:0]  rd_row,
  output logic              done
);
  localparam int DEPTH  = MAX_FOLDS * CIRC_SIZE;
  localparam int ADDR_W = FOLD_W + ROW_W;

  logic              seq_busy, seq_wr;
  logic [FOLD_W-1:0] seq_fold;
  logic [ROW_W-1:0]  seq_row, cur_off;
  logic [ADDR_W-1:0] phys_addr;

  fold_offset_regs #(
    .MAX_FOLDS(MAX_FOLDS), .FOLD_W(FOLD_W), .ROW_W(ROW_W)
  ) u_offsets (
    .clk(clk), .rst(rst), .we(cfg_off_we), .wr_idx(cfg_off_idx),
    .wr_val(cfg_off_val), .rd_idx(seq_fold), .rd_off(cur_off)
  );

  fold_sequencer #(
    .CIRC_SIZE(CIRC_SIZE), .MAX_FOLDS(MAX_FOLDS), .FOLD_W(FOLD_W),
    .ROW_W(ROW_W), .CNT_W(CNT_W)
  ) u_seq (
    .clk(clk), .rst(rst), .start(start), .start_write(start_write),
    .fold_cnt(cfg_fold_cnt), .busy(seq_busy), .fold(seq_fold),
    .row(seq_row), .write_mode(seq_wr), .done(done)
  );

  fold_addr_gen #(
    .FOLD_W(FOLD_W), .ROW_W(ROW_W), .ADDR_W(ADDR_W)
  ) u_addr (
    .fold(seq_fold), .row(seq_row), .offset(cur_off), .addr(phys_addr)
  );

  fold_msg_ram #(
    .DEPTH(DEPTH), .ADDR_W(ADDR_W), .MSG_W(MSG_W),
    .FOLD_W(FOLD_W), .ROW_W(ROW_W)
  ) u_ram (
    .clk(clk), .rst(rst), .en(seq_busy), .we(seq_wr), .addr(phys_addr),
    .wdata(wr_data), .tag_fold(seq_fold), .tag_row(seq_row),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_fold(rd_fold), .rd_row(rd_row)
  );

  assign busy      = seq_busy;
  assign step_fold = seq_fold;
  assign step_row  = seq_row;

  assert_rd_latency_R6: assert property (@(posedge clk) disable iff (rst)
    (seq_busy && !seq_wr) |=> (rd_valid && rd_fold == $past(seq_fold) && rd_row == $past(seq_row)));

  assert_no_rd_in_write_R7: assert property (@(posedge clk) disable iff (rst)
    (seq_busy && seq_wr) |=> !rd_valid);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    !seq_busy |=> !rd_valid);
endmodule

// File: tb/fold_msg_mapper_bench.sv
module fold_msg_mapper_bench;
  localparam int C  = 16;
  localparam int MF = 4;
  localparam int MW = 8;
  localparam int RW = 4;
  localparam int FW = 2;
  localparam int CW = 3;

  logic clk = 1'b0, rst = 1'b1;
  logic cfg_off_we = 1'b0;
  logic [FW-1:0] cfg_off_idx = '0;
  logic [RW-1:0] cfg_off_val = '0;
  logic [CW-1:0] cfg_fold_cnt = '0;
  logic start = 1'b0, start_write = 1'b0;
  logic [MW-1:0] wr_data = '0;
  logic busy, rd_valid, done;
  logic [FW-1:0] step_fold, rd_fold;
  logic [RW-1:0] step_row, rd_row;
  logic [MW-1:0] rd_data;

  int n_cmp = 0, n_bad = 0;
  int exp_mem [MF*C];
  int off_m [MF];

  always #5 clk = ~clk;

  fold_msg_mapper #(.CIRC_SIZE(C), .MAX_FOLDS(MF), .MSG_W(MW)) u_fold_msg_mapper (
    .clk(clk), .rst(rst), .cfg_off_we(cfg_off_we), .cfg_off_idx(cfg_off_idx),
    .cfg_off_val(cfg_off_val), .cfg_fold_cnt(cfg_fold_cnt), .start(start),
    .start_write(start_write), .wr_data(wr_data), .busy(busy),
    .step_fold(step_fold), .step_row(step_row), .rd_valid(rd_valid),
    .rd_data(rd_data), .rd_fold(rd_fold), .rd_row(rd_row), .done(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int phys(input int f, input int r);
    return f * C + ((r + off_m[f]) % C);
  endfunction

  task automatic set_off(input int idx, input int val);
    cfg_off_we  = 1'b1;
    cfg_off_idx = FW'(idx);
    cfg_off_val = RW'(val);
    off_m[idx]  = val;
    @(negedge clk);
    cfg_off_we  = 1'b0;
  endtask

  task automatic run_pass(input int cnt, input bit wr, input int pid, input bit poke);
    int eff, total;
    eff   = (cnt == 0) ? 1 : ((cnt > MF) ? MF : cnt);
    total = eff * C;
    start = 1'b1; start_write = wr; cfg_fold_cnt = CW'(cnt);
    @(negedge clk);
    for (int k = 0; k <= total; k++) begin
      if (poke && k == 3) begin
        start = 1'b1; start_write = ~wr; cfg_fold_cnt = CW'(1);  // R8 poke
      end else begin
        start = 1'b0; start_write = wr; cfg_fold_cnt = CW'(cnt);
      end
      if (k < total) begin
        chk(busy == 1'b1, "R3 busy", int'(busy), 1);
        chk(int'(step_fold) == k / C, "R3 fold order", int'(step_fold), k / C);
        chk(int'(step_row) == k % C, "R3 row order", int'(step_row), k % C);
        chk(done == 1'b0, "R5 done early", int'(done), 0);
        if (wr) begin
          wr_data = MW'((pid << 6) | ((k / C) << 4) | (k % C));
          exp_mem[phys(k / C, k % C)] = int'(wr_data);
        end
      end else begin
        chk(busy == 1'b0, "R5 busy end", int'(busy), 0);
        chk(done == 1'b1, "R5 done pulse", int'(done), 1);
      end
      if (k > 0) begin
        if (wr) begin
          chk(rd_valid == 1'b0, "R7 no read valid", int'(rd_valid), 0);
        end else begin
          chk(rd_valid == 1'b1, "R6 read valid", int'(rd_valid), 1);
          chk(int'(rd_fold) == (k - 1) / C, "R6 rd_fold", int'(rd_fold), (k - 1) / C);
          chk(int'(rd_row) == (k - 1) % C, "R6 rd_row", int'(rd_row), (k - 1) % C);
          chk(int'(rd_data) == exp_mem[phys((k - 1) / C, (k - 1) % C)], "R2 R9 data",
              int'(rd_data), exp_mem[phys((k - 1) / C, (k - 1) % C)]);
        end
      end
      @(negedge clk);
    end
    start = 1'b0;
    chk(done == 1'b0, "R5 single pulse", int'(done), 0);
    chk(busy == 1'b0, "R3 stays idle", int'(busy), 0);
    chk(rd_valid == 1'b0, "R6 valid drops", int'(rd_valid), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < MF; i++) off_m[i] = 0;   // R1: offsets reset to zero
    for (int i = 0; i < MF * C; i++) exp_mem[i] = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(busy == 1'b0, "R1 busy", int'(busy), 0);
    chk(done == 1'b0, "R1 done", int'(done), 0);
    chk(rd_valid == 1'b0, "R1 rd_valid", int'(rd_valid), 0);
    // R1: write all folds with reset offsets, then change offsets
    run_pass(MF, 1'b1, 1, 1'b0);
    run_pass(MF, 1'b0, 0, 1'b0);
    // R10: new offsets, R2: reads see rotation by new offset
    set_off(0, 3); set_off(1, 0); set_off(2, 15); set_off(3, 7);
    run_pass(MF, 1'b0, 0, 1'b0);
    run_pass(MF, 1'b1, 2, 1'b0);
    set_off(0, 5); set_off(1, 9); set_off(2, 1); set_off(3, 12);
    run_pass(MF, 1'b0, 0, 1'b0);
    // R4: count 0 runs one fold, count 7 runs MF; R9: other folds untouched
    run_pass(0, 1'b1, 3, 1'b0);
    run_pass(7, 1'b0, 0, 1'b0);
    // R8: start during a pass is ignored
    run_pass(2, 1'b0, 0, 1'b1);
    run_pass(3, 1'b1, 1, 1'b1);
    set_off(1, 2);
    run_pass(MF, 1'b0, 0, 1'b0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule